// File: doc/BRIEF.md
# Sampling Margin Monitor with Automatic Clock-Delay Steering

This block checks whether a parallel input bus is being captured with enough timing margin. Each sample of the bus arrives three times: the nominal capture that the datapath uses, an early capture taken a set margin ahead of the nominal instant, and a late capture taken the same margin after it. When either extra capture disagrees with the nominal one, the block flags a timing error for that sample. It records whether the failure was on the setup side or the hold side, and it raises an interrupt flag that stays set until it is cleared.

The margin setting and a host-chosen delay code are registered on entry. The margin goes out to the delay model that produces the early and late captures. The 5-bit delay code shifts the interface clock. In manual mode the code follows the host value. In automatic mode the block runs a closed loop instead. A setup error moves the code up by one and a hold error moves it down by one. The code saturates at either end, and a settle interval separates steps so that the effect of each step can be seen before the next one. The applied code is always visible on an output port.

Top module: `sample_margin_tuner`

## Requirements
- R1: `err_flag` is high in the cycle after a sample with `cap_valid` high whose early or late capture differs from the nominal capture. It is low after every other cycle, including mismatching cycles with `cap_valid` low.
- R2: On each error, `err_type` is set to 1 (setup) when the early capture mismatched, including when both mismatched. It is set to 0 (hold) when only the late capture mismatched. It updates one cycle after `err_flag`.
- R3: `err_type` keeps its value across cycles without an error.
- R4: `irq` is set one cycle after `err_flag` and stays set until a one-cycle `irq_clr` pulse. If an error and a clear arrive in the same cycle, the set wins.
- R5: With `auto_en` low, `delay_code` takes the value of `delay_cfg` one cycle later, and errors do not change it.
- R6: With `auto_en` high and the settle interval elapsed, `delay_code` rises by one on the edge after a setup `err_flag` and falls by one on the edge after a hold `err_flag`.
- R7: The delay code saturates at 0 and 31 and never wraps.
- R8: At least SETTLE clocks (default 16) separate two automatic changes of `delay_code`. Error samples that arrive inside the interval are ignored.
- R9: `margin_out` shows `margin_cfg` one cycle later. A change of `margin_cfg`, `delay_cfg` or `auto_en` restarts the settle interval.
- R10: After reset, `delay_code` is 16, `margin_out` is 0, and `irq`, `err_flag` and `err_type` are 0.
- R11: When automatic mode is entered, stepping starts from the code that was applied at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | The three captures hold a sample in this cycle |
| cap_early | input | DATA_W | Capture taken the margin before nominal |
| cap_nom | input | DATA_W | Nominal capture |
| cap_late | input | DATA_W | Capture taken the margin after nominal |
| margin_cfg | input | MARGIN_W | Host margin setting |
| delay_cfg | input | DELAY_W | Host delay code, used in manual mode |
| auto_en | input | 1 | Enables automatic delay steering |
| irq_clr | input | 1 | One-cycle clear of the interrupt flag |
| margin_out | output | MARGIN_W | Registered margin sent to the delay model |
| delay_code | output | DELAY_W | Applied interface clock delay code |
| err_flag | output | 1 | Timing error seen on the previous sample |
| err_type | output | 1 | Last error kind: 1 setup, 0 hold |
| irq | output | 1 | Sticky timing-error interrupt |

## Verification
A wrong detection or classification state shows on `err_flag` one cycle after the sample and on `err_type` and `irq` one cycle after that. A corrupt delay register or a wrong step direction shows on `delay_code` on the second edge after an error sample. A settle counter that restarts late or not at all only shows up as a delay step that appears when it should not, or fails to appear, within SETTLE+2 cycles of a configuration change. The tests therefore probe that window from both sides.

// File: rtl/smt_pkg.sv
package smt_pkg;

    // Default widths and timing shared by the block and its bench
    localparam int unsigned DEF_DATA_W     = 16;
    localparam int unsigned DEF_MARGIN_W   = 4;
    localparam int unsigned DEF_DELAY_W    = 5;
    localparam int unsigned DEF_SETTLE     = 16;
    localparam int unsigned DEF_DELAY_INIT = 16;

    // Kind of margin violation
    typedef enum logic {
        KIND_HOLD  = 1'b0,
        KIND_SETUP = 1'b1
    } err_kind_e;

    // Registered result of one sample comparison
    typedef struct packed {
        logic      err;
        err_kind_e kind;
    } det_t;

    // Direction requested of the delay controller
    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b10
    } step_e;

    function automatic step_e step_for(input det_t d);
        if (!d.err)                 return STEP_NONE;
        else if (d.kind == KIND_SETUP) return STEP_UP;
        else                        return STEP_DOWN;
    endfunction

endpackage

// File: rtl/smt_detect.sv
module smt_detect
    import smt_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [DATA_W-1:0] early,
    input  logic [DATA_W-1:0] nom,
    input  logic [DATA_W-1:0] late,
    output det_t              det
);

    logic early_miss;
    logic late_miss;
    det_t det_d;

    assign early_miss = (early != nom);
    assign late_miss  = (late  != nom);

    // Early mismatch classifies as setup and wins over a late mismatch
    always_comb begin
        det_d.err  = valid && (early_miss || late_miss);
        det_d.kind = early_miss ? KIND_SETUP : KIND_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det <= '{err: 1'b0, kind: KIND_HOLD};
        end else begin
            det <= det_d;
        end
    end

endmodule

// File: rtl/smt_settle.sv
module smt_settle #(
    parameter int unsigned SETTLE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic ready
);

    localparam int unsigned CW = $clog2(SETTLE + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = (cnt == LIMIT);

endmodule

// File: rtl/smt_delay_ctrl.sv
module smt_delay_ctrl
    import smt_pkg::*;
#(
    parameter int unsigned DELAY_W    = DEF_DELAY_W,
    parameter int unsigned DELAY_INIT = DEF_DELAY_INIT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               auto_en,
    input  logic [DELAY_W-1:0] manual_code,
    input  det_t               det,
    input  logic               ready,
    output logic               step_fire,
    output logic [DELAY_W-1:0] code
);

    localparam logic [DELAY_W-1:0] CODE_MAX  = '1;
    localparam logic [DELAY_W-1:0] CODE_MIN  = '0;
    localparam logic [DELAY_W-1:0] CODE_INIT = DELAY_W'(DELAY_INIT);

    step_e              req;
    logic [DELAY_W-1:0] next_auto;

    assign req       = step_for(det);
    assign step_fire = auto_en && ready && (req != STEP_NONE);

    // Saturating one-step move
    always_comb begin
        next_auto = code;
        unique case (req)
            STEP_UP:   if (code != CODE_MAX) next_auto = code + 1'b1;
            STEP_DOWN: if (code != CODE_MIN) next_auto = code - 1'b1;
            default:   next_auto = code;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= CODE_INIT;
        end else if (!auto_en) begin
            code <= manual_code;
        end else if (step_fire) begin
            code <= next_auto;
        end
    end

endmodule

// File: rtl/sample_margin_tuner.sv
module sample_margin_tuner
    import smt_pkg::*;
#(
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter int unsigned MARGIN_W   = DEF_MARGIN_W,
    parameter int unsigned DELAY_W    = DEF_DELAY_W,
    parameter int unsigned SETTLE     = DEF_SETTLE,
    parameter int unsigned DELAY_INIT = DEF_DELAY_INIT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cap_valid,
    input  logic [DATA_W-1:0]   cap_early,
    input  logic [DATA_W-1:0]   cap_nom,
    input  logic [DATA_W-1:0]   cap_late,
    input  logic [MARGIN_W-1:0] margin_cfg,
    input  logic [DELAY_W-1:0]  delay_cfg,
    input  logic                auto_en,
    input  logic                irq_clr,
    output logic [MARGIN_W-1:0] margin_out,
    output logic [DELAY_W-1:0]  delay_code,
    output logic                err_flag,
    output logic                err_type,
    output logic                irq
);

    logic [MARGIN_W-1:0] margin_q;
    logic [DELAY_W-1:0]  dcfg_q;
    logic                auto_q;
    logic                cfg_touch;
    det_t                det;
    logic                ready;
    logic                step_fire;
    logic                irq_q;
    err_kind_e           kind_q;

    // Registered host settings and change detection
    always_ff @(posedge clk) begin
        if (rst) begin
            margin_q <= '0;
            dcfg_q   <= DELAY_W'(DELAY_INIT);
            auto_q   <= 1'b0;
        end else begin
            margin_q <= margin_cfg;
            dcfg_q   <= delay_cfg;
            auto_q   <= auto_en;
        end
    end

    assign cfg_touch = (margin_cfg != margin_q) ||
                       (delay_cfg  != dcfg_q)   ||
                       (auto_en    != auto_q);

    smt_detect #(
        .DATA_W (DATA_W)
    ) u_detect (
        .clk   (clk),
        .rst   (rst),
        .valid (cap_valid),
        .early (cap_early),
        .nom   (cap_nom),
        .late  (cap_late),
        .det   (det)
    );

    smt_settle #(
        .SETTLE (SETTLE)
    ) u_settle (
        .clk     (clk),
        .rst     (rst),
        .restart (cfg_touch || step_fire),
        .ready   (ready)
    );

    smt_delay_ctrl #(
        .DELAY_W    (DELAY_W),
        .DELAY_INIT (DELAY_INIT)
    ) u_delay (
        .clk         (clk),
        .rst         (rst),
        .auto_en     (auto_en),
        .manual_code (delay_cfg),
        .det         (det),
        .ready       (ready),
        .step_fire   (step_fire),
        .code        (delay_code)
    );

    // Sticky interrupt and last error kind
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            kind_q <= KIND_HOLD;
        end else begin
            irq_q <= (irq_q && !irq_clr) || det.err;
            if (det.err) begin
                kind_q <= det.kind;
            end
        end
    end

    assign margin_out = margin_q;
    assign err_flag   = det.err;
    assign err_type   = kind_q;
    assign irq        = irq_q;

endmodule

// File: rtl/smt_checker.sv
module smt_checker #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned MARGIN_W = 4,
    parameter int unsigned DELAY_W  = 5,
    parameter int unsigned SETTLE   = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                cap_valid,
    input logic [DATA_W-1:0]   cap_early,
    input logic [DATA_W-1:0]   cap_nom,
    input logic [DATA_W-1:0]   cap_late,
    input logic [MARGIN_W-1:0] margin_cfg,
    input logic [DELAY_W-1:0]  delay_cfg,
    input logic                auto_en,
    input logic                irq_clr,
    input logic [MARGIN_W-1:0] margin_out,
    input logic [DELAY_W-1:0]  delay_code,
    input logic                err_flag,
    input logic                err_type,
    input logic                irq
);

    localparam int unsigned GW = $clog2(SETTLE + 2);
    localparam logic [GW-1:0] GMAX = GW'(SETTLE + 1);

    logic               past_ok;
    logic               auto_prev;
    logic [DELAY_W-1:0] code_prev;
    logic [GW-1:0]      gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok   <= 1'b0;
            auto_prev <= 1'b0;
            code_prev <= '0;
            gap       <= GMAX;
        end else begin
            past_ok   <= 1'b1;
            auto_prev <= auto_en;
            code_prev <= delay_code;
            if (past_ok && delay_code != code_prev) gap <= GW'(1);
            else if (gap != GMAX)                   gap <= gap + 1'b1;
        end
    end

    // R1
    err_source_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && err_flag) |->
        $past(cap_valid && (cap_early != cap_nom || cap_late != cap_nom)));

    // R3
    type_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$stable(err_type)) |-> $past(err_flag));

    // R4
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $fell(irq)) |-> $past(irq_clr));

    // R5
    manual_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !auto_prev) |-> (delay_code == code_prev || delay_code == $past(delay_cfg)));

    // R7
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && auto_prev && delay_code != code_prev) |->
        (delay_code == code_prev + 1'b1 && code_prev != '1) ||
        (delay_code == code_prev - 1'b1 && code_prev != '0));

    // R8
    settle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && auto_prev && delay_code != code_prev) |-> (gap >= GW'(SETTLE)));

    // R9
    margin_reg_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (margin_out == $past(margin_cfg)));

endmodule

bind sample_margin_tuner smt_checker #(
    .DATA_W   (DATA_W),
    .MARGIN_W (MARGIN_W),
    .DELAY_W  (DELAY_W),
    .SETTLE   (SETTLE)
) u_smt_checker (
    .clk        (clk),
    .rst        (rst),
    .cap_valid  (cap_valid),
    .cap_early  (cap_early),
    .cap_nom    (cap_nom),
    .cap_late   (cap_late),
    .margin_cfg (margin_cfg),
    .delay_cfg  (delay_cfg),
    .auto_en    (auto_en),
    .irq_clr    (irq_clr),
    .margin_out (margin_out),
    .delay_code (delay_code),
    .err_flag   (err_flag),
    .err_type   (err_type),
    .irq        (irq)
);

// File: tb/test_sample_margin_tuner.sv
module test_sample_margin_tuner;
    import smt_pkg::*;

    localparam int unsigned DW     = DEF_DATA_W;
    localparam int unsigned MW     = DEF_MARGIN_W;
    localparam int unsigned KW     = DEF_DELAY_W;
    localparam int unsigned SETTLE = DEF_SETTLE;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cap_valid = 1'b0;
    logic [DW-1:0] cap_early = '0;
    logic [DW-1:0] cap_nom = '0;
    logic [DW-1:0] cap_late = '0;
    logic [MW-1:0] margin_cfg = '0;
    logic [KW-1:0] delay_cfg = KW'(16);
    logic          auto_en = 1'b0;
    logic          irq_clr = 1'b0;
    logic [MW-1:0] margin_out;
    logic [KW-1:0] delay_code;
    logic          err_flag;
    logic          err_type;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sample_margin_tuner i_sample_margin_tuner (
        .clk        (clk),
        .rst        (rst),
        .cap_valid  (cap_valid),
        .cap_early  (cap_early),
        .cap_nom    (cap_nom),
        .cap_late   (cap_late),
        .margin_cfg (margin_cfg),
        .delay_cfg  (delay_cfg),
        .auto_en    (auto_en),
        .irq_clr    (irq_clr),
        .margin_out (margin_out),
        .delay_code (delay_code),
        .err_flag   (err_flag),
        .err_type   (err_type),
        .irq        (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // kind: 0 clean, 1 early mismatch, 2 late mismatch, 3 both
    task automatic sample(input int kind, input logic v);
        logic [DW-1:0] d;
        d = DW'($urandom);
        cap_valid = v;
        cap_nom   = d;
        cap_early = (kind == 1 || kind == 3) ? ~d : d;
        cap_late  = (kind == 2 || kind == 3) ? d ^ DW'(1) : d;
        @(negedge clk);
        cap_valid = 1'b0;
        cap_early = '0;
        cap_nom   = '0;
        cap_late  = '0;
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 delay", delay_code, 16);
        check("R10 irq", irq, 0);
        check("R10 err", err_flag, 0);
        check("R10 type", err_type, 0);
        check("R10 margin", margin_out, 0);
    endtask

    task automatic t_clean();
        for (int i = 0; i < 6; i++) begin
            sample(0, 1'b1);
            check("R1 clean err", err_flag, 0);
        end
        sample(3, 1'b0);
        check("R1 invalid err", err_flag, 0);
        idle(1);
        check("R1 invalid irq", irq, 0);
    endtask

    task automatic t_manual();
        delay_cfg = KW'(5);
        margin_cfg = MW'(9);
        @(negedge clk);
        check("R5 manual code", delay_code, 5);
        check("R9 margin out", margin_out, 9);
        sample(1, 1'b1);
        check("R1 err setup", err_flag, 1);
        idle(2);
        check("R5 no step in manual", delay_code, 5);
    endtask

    task automatic t_classify();
        clear_irq();
        check("R4 cleared", irq, 0);
        sample(2, 1'b1);
        check("R1 err hold", err_flag, 1);
        @(negedge clk);
        check("R2 hold type", err_type, 0);
        check("R4 irq set", irq, 1);
        idle(3);
        check("R4 irq sticky", irq, 1);
        check("R3 type held", err_type, 0);
        sample(3, 1'b1);
        @(negedge clk);
        check("R2 both is setup", err_type, 1);
        sample(0, 1'b1);
        idle(1);
        check("R3 type held setup", err_type, 1);
        // clear and error together: set wins
        sample(2, 1'b1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R4 set wins", irq, 1);
        check("R2 late only hold", err_type, 0);
        clear_irq();
        check("R4 clear", irq, 0);
    endtask

    task automatic t_auto();
        auto_en = 1'b1;
        idle(SETTLE + 3);
        check("R11 start code", delay_code, 5);
        sample(1, 1'b1);
        sample(0, 1'b1);
        check("R6 step up", delay_code, 6);
        sample(1, 1'b1);
        sample(0, 1'b1);
        idle(1);
        check("R8 inside settle", delay_code, 6);
        idle(SETTLE);
        sample(2, 1'b1);
        sample(0, 1'b1);
        check("R6 step down", delay_code, 5);
    endtask

    task automatic t_restart();
        idle(SETTLE + 2);
        margin_cfg = MW'(3);
        sample(0, 1'b1);
        check("R9 margin new", margin_out, 3);
        sample(1, 1'b1);
        sample(0, 1'b1);
        check("R9 restart blocks", delay_code, 5);
        idle(SETTLE + 2);
        sample(1, 1'b1);
        sample(0, 1'b1);
        check("R9 after restart", delay_code, 6);
    endtask

    task automatic t_saturate();
        auto_en = 1'b0;
        delay_cfg = KW'(31);
        idle(2);
        check("R5 manual 31", delay_code, 31);
        auto_en = 1'b1;
        idle(SETTLE + 3);
        sample(1, 1'b1);
        sample(0, 1'b1);
        idle(1);
        check("R7 top hold", delay_code, 31);
        auto_en = 1'b0;
        delay_cfg = KW'(0);
        idle(2);
        auto_en = 1'b1;
        idle(SETTLE + 3);
        sample(2, 1'b1);
        sample(0, 1'b1);
        idle(1);
        check("R7 bottom hold", delay_code, 0);
        idle(SETTLE + 2);
        sample(1, 1'b1);
        sample(0, 1'b1);
        check("R6 up from zero", delay_code, 1);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        t_reset();
        idle(2);
        t_clean();
        t_manual();
        t_classify();
        t_auto();
        t_restart();
        t_saturate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule